// File: doc/BRIEF.md
# Byte pattern and divisibility classifier

This block takes one byte and reports a set of its properties at the same time: how many bits are set, whether that count is odd, how long the run of ones is at each end, whether the byte reads the same mirrored end to end, several comparisons of the bit count against fixed and selectable limits, and whether the byte's unsigned value divides evenly by each integer from 2 to 12. All results are produced in parallel from the same input.

Every decision inside the block comes from a single primitive, a threshold neuron. The neuron fires when a weighted sum of its inputs plus a bias is at least zero, and every weight is -1, 0 or +1. Functions that one neuron can separate use one layer. These are the count thresholds, the run-length steps and divisibility by 2, 4 and 8. Functions that one neuron cannot separate use more layers. Parity is a tree of two-layer XOR cells. Divisibility by 3, 5, 6, 7, 9, 10, 11 and 12 uses a layer of exact-value detectors feeding an OR neuron.

A parameter adds an output register with an active-low asynchronous reset. With the register in place, which is the default, every result appears one clock after its input.

Top module: `byte_classifier`

## Requirements
- R1: `pop_cnt` equals the number of set bits of `din`, from 0 to 8.
- R2: `parity` is 1 exactly when `din` has an odd number of set bits.
- R3: `lead_ones` counts consecutive ones starting at bit 7 and going down, and `trail_ones` counts consecutive ones starting at bit 0 and going up. Each count is 0 when its starting bit is 0 and 8 for 0xFF.
- R4: `symmetric` is 1 exactly when bit i equals bit 7-i for every i from 0 to 3.
- R5: `at_least_k` is 1 when the set-bit count is at least `k_sel`. It is always 1 for `k_sel` = 0 and always 0 for `k_sel` above 8.
- R6: `exactly_k` is 1 when the set-bit count equals `k_sel`. It is 0 for every `k_sel` above 8.
- R7: `majority` is 1 for a set-bit count of 5 or more, and `minority` is 1 for a count of 3 or less. A count of exactly 4 drives both to 0.
- R8: `div_mask` bit (d-2) is 1 exactly when the unsigned value of `din` is a multiple of d, for each d from 2 to 12.
- R9: An input of 0 sets every bit of `div_mask`.
- R10: With the output register enabled, every output shows the result for the `din` and `k_sel` sampled at the previous rising clock edge. While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| din | input | 8 | Byte under analysis |
| k_sel | input | 4 | Selectable count limit for `at_least_k` and `exactly_k` |
| pop_cnt | output | 4 | Number of set bits |
| lead_ones | output | 4 | Run of ones from bit 7 downward |
| trail_ones | output | 4 | Run of ones from bit 0 upward |
| parity | output | 1 | Odd-count flag |
| symmetric | output | 1 | Mirror-symmetry flag |
| at_least_k | output | 1 | Count is at least `k_sel` |
| exactly_k | output | 1 | Count equals `k_sel` |
| majority | output | 1 | Count is 5 or more |
| minority | output | 1 | Count is 3 or less |
| div_mask | output | 11 | Bit d-2 set when `din` is divisible by d |

## Verification
The hardest condition to reach from the ports is the full cross of a value with the count limit. This covers `k_sel` values of 9 and above, which match no possible count, and every byte whose count sits exactly on the limit or one away from it. Each divisor network also has a large set of exact-value detectors, and an error in any one of them shows up only for a single byte value. The stimulus therefore sweeps all 256 bytes once for every `k_sel` from 0 to 9 and compares each output with arithmetic computed in the bench. Hand-chosen table vectors, reset checks and a check of the one-clock latency follow the sweep.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

    // How a divisibility detector is built
    typedef enum logic {
        DK_SINGLE_LAYER,
        DK_MULTI_LAYER
    } div_kind_e;

    function automatic int ones32(input logic [31:0] v);
        int n;
        n = 0;
        for (int i = 0; i < 32; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic div_kind_e div_kind(input int d);
        return ((d & (d - 1)) == 0) ? DK_SINGLE_LAYER : DK_MULTI_LAYER;
    endfunction

    // Number of multiples of d in 0 .. 2**w - 1
    function automatic int mult_count(input int d, input int w);
        return ((1 << w) - 1) / d + 1;
    endfunction

endpackage

// File: rtl/bpc_neuron.sv
// Threshold unit with weights restricted to -1, 0, +1.
module bpc_neuron #(
    parameter int N = 2,
    parameter logic [N-1:0] POS = '0,
    parameter logic [N-1:0] NEG = '0,
    parameter int BIAS = 0
) (
    input  logic [N-1:0] x,
    output logic         fire
);
    int acc;

    always_comb begin
        acc  = BIAS + $countones(x & POS) - $countones(x & NEG);
        fire = (acc >= 0);
    end
endmodule

// File: rtl/bpc_xor2.sv
// Two-layer XOR (or XNOR with INVERT=1) made of threshold units.
module bpc_xor2 #(
    parameter bit INVERT = 1'b0
) (
    input  logic a,
    input  logic b,
    output logic y
);
    logic any_one, not_both, xo;

    bpc_neuron #(.N(2), .POS(2'b11), .NEG(2'b00), .BIAS(-1))
        u_or   (.x({a, b}), .fire(any_one));
    bpc_neuron #(.N(2), .POS(2'b00), .NEG(2'b11), .BIAS(1))
        u_nand (.x({a, b}), .fire(not_both));
    bpc_neuron #(.N(2), .POS(2'b11), .NEG(2'b00), .BIAS(-2))
        u_and  (.x({any_one, not_both}), .fire(xo));

    generate
        if (INVERT) begin : g_inv
            bpc_neuron #(.N(1), .POS(1'b0), .NEG(1'b1), .BIAS(0))
                u_not (.x(xo), .fire(y));
        end else begin : g_pass
            assign y = xo;
        end
    endgenerate
endmodule

// File: rtl/bpc_parity.sv
// XOR tree in heap order: leaves 0..W-1, gate j writes node W+j.
module bpc_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    output logic         odd
);
    localparam int NODES = 2 * W - 1;

    logic [NODES-1:0] node;

    assign node[W-1:0] = x;

    generate
        for (genvar j = 0; j < W - 1; j++) begin : g_gate
            bpc_xor2 #(.INVERT(1'b0)) u_x (
                .a(node[2*j]),
                .b(node[2*j+1]),
                .y(node[W+j])
            );
        end
    endgenerate

    assign odd = node[NODES-1];
endmodule

// File: rtl/bpc_runs.sv
// Length of the run of ones from one end of the word.
module bpc_runs #(
    parameter int W = 8,
    parameter bit FROM_MSB = 1'b1,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  x,
    output logic [CW-1:0] run_len
);
    logic [W-1:0] step;   // step[j-1]: first j bits from the chosen end are all ones

    generate
        for (genvar j = 1; j <= W; j++) begin : g_step
            localparam logic [W-1:0] LOWM  = {W{1'b1}} >> (W - j);
            localparam logic [W-1:0] HIGHM = {W{1'b1}} << (W - j);
            localparam logic [W-1:0] MASK  = FROM_MSB ? HIGHM : LOWM;
            bpc_neuron #(.N(W), .POS(MASK), .NEG('0), .BIAS(-j))
                u_n (.x(x), .fire(step[j-1]));
        end
    endgenerate

    always_comb begin
        run_len = '0;
        for (int j = 0; j < W; j++) run_len = run_len + CW'(step[j]);
    end
endmodule

// File: rtl/bpc_symmetry.sv
// Mirror test: XNOR per bit pair, then an AND unit.
module bpc_symmetry #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    output logic         mirrored
);
    localparam int PAIRS = W / 2;

    logic [PAIRS-1:0] same;

    generate
        for (genvar i = 0; i < PAIRS; i++) begin : g_pair
            bpc_xor2 #(.INVERT(1'b1)) u_eq (
                .a(x[i]),
                .b(x[W-1-i]),
                .y(same[i])
            );
        end
    endgenerate

    bpc_neuron #(.N(PAIRS), .POS({PAIRS{1'b1}}), .NEG('0), .BIAS(-PAIRS))
        u_all (.x(same), .fire(mirrored));
endmodule

// File: rtl/bpc_divisor.sv
// Divisibility of an unsigned word by constant D.
module bpc_divisor #(
    parameter int W = 8,
    parameter int D = 3
) (
    input  logic [W-1:0] x,
    output logic         hit
);
    import bpc_pkg::*;

    localparam div_kind_e KIND = div_kind(D);
    localparam int M = mult_count(D, W);

    generate
        if (KIND == DK_SINGLE_LAYER) begin : g_single
            // fires when the low log2(D) bits are all zero
            bpc_neuron #(.N(W), .POS('0), .NEG(W'(D - 1)), .BIAS(0))
                u_n (.x(x), .fire(hit));
        end else begin : g_multi
            logic [M-1:0] is_val;
            for (genvar m = 0; m < M; m++) begin : g_eq
                localparam logic [W-1:0] VAL = W'(m * D);
                bpc_neuron #(.N(W), .POS(VAL), .NEG(~VAL),
                             .BIAS(-ones32(32'(VAL))))
                    u_eq (.x(x), .fire(is_val[m]));
            end
            bpc_neuron #(.N(M), .POS({M{1'b1}}), .NEG('0), .BIAS(-1))
                u_or (.x(is_val), .fire(hit));
        end
    endgenerate
endmodule

// File: rtl/byte_classifier.sv
module byte_classifier #(
    parameter int W = 8,
    parameter int MAX_DIV = 12,
    parameter bit OUT_REG = 1'b1,
    localparam int CW = $clog2(W + 1),
    localparam int KW = $clog2(W + 2),
    localparam int NDIV = MAX_DIV - 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W-1:0]    din,
    input  logic [KW-1:0]   k_sel,
    output logic [CW-1:0]   pop_cnt,
    output logic [CW-1:0]   lead_ones,
    output logic [CW-1:0]   trail_ones,
    output logic            parity,
    output logic            symmetric,
    output logic            at_least_k,
    output logic            exactly_k,
    output logic            majority,
    output logic            minority,
    output logic [NDIV-1:0] div_mask
);
    localparam int BW = 3 * CW + 6 + NDIV;

    // ---------------- count thresholds ----------------
    logic [W+1:0] th;       // th[k]: count >= k; th[0]=1, th[W+1]=0
    logic [W+1:0] th_sh;
    logic [CW-1:0] c_pop;
    logic c_atl, c_exk, c_maj, c_min;

    assign th[0]   = 1'b1;
    assign th[W+1] = 1'b0;

    generate
        for (genvar k = 1; k <= W; k++) begin : g_thr
            bpc_neuron #(.N(W), .POS({W{1'b1}}), .NEG('0), .BIAS(-k))
                u_k (.x(din), .fire(th[k]));
        end
    endgenerate

    always_comb begin
        c_pop = '0;
        for (int k = 1; k <= W; k++) c_pop = c_pop + CW'(th[k]);
        th_sh = th >> k_sel;
        c_atl = th_sh[0];
        c_exk = th_sh[0] & ~th_sh[1];
        c_maj = th[W/2 + 1];
        c_min = ~th[W/2];
    end

    // ---------------- pattern networks ----------------
    logic [CW-1:0] c_lead, c_trail;
    logic c_par, c_sym;
    logic [NDIV-1:0] c_div;

    bpc_runs #(.W(W), .FROM_MSB(1'b1)) u_lead  (.x(din), .run_len(c_lead));
    bpc_runs #(.W(W), .FROM_MSB(1'b0)) u_trail (.x(din), .run_len(c_trail));
    bpc_parity   #(.W(W)) u_par (.x(din), .odd(c_par));
    bpc_symmetry #(.W(W)) u_sym (.x(din), .mirrored(c_sym));

    generate
        for (genvar d = 2; d <= MAX_DIV; d++) begin : g_div
            bpc_divisor #(.W(W), .D(d)) u_d (.x(din), .hit(c_div[d-2]));
        end
    endgenerate

    // ---------------- optional output stage ----------------
    logic [BW-1:0] comb_bus, out_bus;

    assign comb_bus = {c_pop, c_lead, c_trail, c_par, c_sym,
                       c_atl, c_exk, c_maj, c_min, c_div};

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) out_bus <= '0;
                else        out_bus <= comb_bus;
            end

            p_pop_r1: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> pop_cnt == CW'($countones($past(din))));
            p_parity_r2: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> parity == ^$past(din));
            p_exact_in_atl_r6: assert property (@(posedge clk) disable iff (!rst_n)
                exactly_k |-> at_least_k);
            p_maj_min_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !(majority && minority));
            p_zero_all_div_r9: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(din) == '0) |-> (&div_mask));
            p_div2_r8: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> div_mask[0] == ~$past(din[0]));
        end else begin : g_comb
            assign out_bus = comb_bus;
        end
    endgenerate

    assign {pop_cnt, lead_ones, trail_ones, parity, symmetric,
            at_least_k, exactly_k, majority, minority, div_mask} = out_bus;
endmodule

// File: tb/byte_classifier_bench.sv
`timescale 1ns/1ps
module byte_classifier_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  din = 8'hFF;
    logic [3:0]  k_sel = 4'd0;
    logic [3:0]  pop_cnt, lead_ones, trail_ones;
    logic        parity, symmetric, at_least_k, exactly_k, majority, minority;
    logic [10:0] div_mask;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;   // 250 MHz

    byte_classifier u_byte_classifier (
        .clk(clk), .rst_n(rst_n), .din(din), .k_sel(k_sel),
        .pop_cnt(pop_cnt), .lead_ones(lead_ones), .trail_ones(trail_ones),
        .parity(parity), .symmetric(symmetric), .at_least_k(at_least_k),
        .exactly_k(exactly_k), .majority(majority), .minority(minority),
        .div_mask(div_mask)
    );

    // {din, k, pop, lead, trail, parity, symmetric}
    localparam logic [25:0] VEC [9] = '{
        {8'h00, 4'd0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b1},
        {8'hFF, 4'd8, 4'd8, 4'd8, 4'd8, 1'b0, 1'b1},
        {8'h81, 4'd2, 4'd2, 4'd1, 4'd1, 1'b0, 1'b1},
        {8'hF0, 4'd4, 4'd4, 4'd4, 4'd0, 1'b0, 1'b0},
        {8'h0F, 4'd4, 4'd4, 4'd0, 4'd4, 1'b0, 1'b0},
        {8'hE7, 4'd6, 4'd6, 4'd3, 4'd3, 1'b0, 1'b1},
        {8'h80, 4'd1, 4'd1, 4'd1, 4'd0, 1'b1, 1'b0},
        {8'h7F, 4'd7, 4'd7, 4'd0, 4'd7, 1'b1, 1'b0},
        {8'h3C, 4'd4, 4'd4, 4'd0, 4'd0, 1'b0, 1'b1}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (din=%02h k=%0d)",
                     tag, act, exp, din, k_sel);
        end
    endtask

    // drive right after a falling edge, sample at the next falling edge
    task automatic apply(input logic [7:0] v, input logic [3:0] k);
        din = v;
        k_sel = k;
        @(negedge clk);
    endtask

    task automatic check_all(input logic [7:0] v, input int k);
        int pc, ld, tr;
        logic [10:0] dm;
        pc = 0;
        for (int i = 0; i < 8; i++) pc += int'(v[i]);
        ld = 0;
        for (int i = 7; i >= 0 && v[i]; i--) ld++;
        tr = 0;
        for (int i = 0; i < 8 && v[i]; i++) tr++;
        for (int d = 2; d <= 12; d++) dm[d-2] = ((int'(v) % d) == 0);
        chk("R1 pop_cnt", pop_cnt, pc);
        chk("R2 parity", parity, pc % 2);
        chk("R3 lead_ones", lead_ones, ld);
        chk("R3 trail_ones", trail_ones, tr);
        chk("R4 symmetric", symmetric,
            int'(v == {v[0], v[1], v[2], v[3], v[4], v[5], v[6], v[7]}));
        chk("R5 at_least_k", at_least_k, int'(pc >= k));
        chk("R6 exactly_k", exactly_k, int'(pc == k));
        chk("R7 majority", majority, int'(pc >= 5));
        chk("R7 minority", minority, int'(pc <= 3));
        chk("R8 div_mask", int'(div_mask), int'(dm));
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        // R10: outputs held at 0 during reset despite a busy input
        repeat (3) @(negedge clk);
        chk("R10 reset pop_cnt", pop_cnt, 0);
        chk("R10 reset div_mask", int'(div_mask), 0);
        chk("R10 reset flags", int'({parity, symmetric, at_least_k, majority}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // full sweep: every byte for every k from 0 to 9 (R1..R8)
        for (int k = 0; k <= 9; k++) begin
            for (int v = 0; v < 256; v++) begin
                apply(8'(v), 4'(k));
                check_all(8'(v), k);
            end
        end

        // k values far beyond 8 (R5, R6)
        apply(8'hFF, 4'd15);
        chk("R5 k=15 at_least_k", at_least_k, 0);
        chk("R6 k=15 exactly_k", exactly_k, 0);
        apply(8'h00, 4'd0);
        chk("R5 k=0 always true", at_least_k, 1);
        chk("R9 zero divisible by all", int'(div_mask), 11'h7FF);

        // hand table (R1..R4)
        for (int i = 0; i < 9; i++) begin
            apply(VEC[i][25:18], VEC[i][17:14]);
            chk("R1 table pop", pop_cnt, int'(VEC[i][13:10]));
            chk("R3 table lead", lead_ones, int'(VEC[i][9:6]));
            chk("R3 table trail", trail_ones, int'(VEC[i][5:2]));
            chk("R2 table parity", parity, int'(VEC[i][1]));
            chk("R4 table symmetric", symmetric, int'(VEC[i][0]));
        end

        // R7 boundary: count of exactly 4
        apply(8'h55, 4'd4);
        chk("R7 count4 majority", majority, 0);
        chk("R7 count4 minority", minority, 0);

        // R10 latency: new input invisible until the next rising edge
        apply(8'h00, 4'd0);
        din = 8'hFF;
        #1;
        chk("R10 before edge pop", pop_cnt, 0);
        @(negedge clk);
        chk("R10 after edge pop", pop_cnt, 8);

        // R10 mid-run reset
        rst_n = 1'b0;
        #1;
        chk("R10 async reset pop", pop_cnt, 0);
        chk("R10 async reset div", int'(div_mask), 0);
        @(negedge clk);
        rst_n = 1'b1;
        apply(8'd60, 4'd4);
        check_all(8'd60, 4);

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule